// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers single-cycle event pulses coming from a display controller's timing and DMA logic and turns them into one interrupt line for software. Each event sets a sticky bit in a raw status register. An enable mask selects which of those bits may raise the interrupt, and a masked status view shows only the enabled ones. Software changes the mask only through two write-one registers: one sets mask bits and one clears them. Status bits are cleared by writing ones to the masked status address. This means a value just read from that address can be written back to acknowledge exactly what was seen.

The interrupt output is a one-cycle pulse. Once it has pulsed, the unit disarms. It stays silent until software writes the end-of-interrupt register to mark servicing complete. After that write the unit is armed again and pulses at once if any enabled event is still pending. The register port is a plain single-cycle interface: a write takes effect at the next clock edge, and the read data is a combinational function of the address.

Event bits are fixed: 0 frame done, 1 raster done, 2 sync lost, 3 AC-bias count, 5 FIFO underflow, 6 palette loaded, 8 end of frame for buffer 0, 9 end of frame for buffer 1. Bits 4 and 7 are not implemented.

Top module: `dispc_irq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0, `irq_o` is low and the unit is armed.
- R2: A high `evt_i` bit at position 0, 1, 2, 3, 5, 6, 8 or 9 sets the same bit of the raw status register (address 0) at the next clock edge. The mask has no effect on this. Bits 4, 7 and every bit from 10 upward always read 0.
- R3: The masked status register (address 1) reads as the raw status ANDed with the enable mask.
- R4: Writing to the enable-set register (address 2) turns on the mask bits where the written data has a one. Zero bits leave the mask unchanged.
- R5: Writing to the enable-clear register (address 3) turns off the mask bits where the written data has a one. Zero bits leave the mask unchanged.
- R6: Reads of address 2 and of address 3 both return the current enable mask.
- R7: Writing to address 1 clears exactly the raw status bits written as one, whatever the mask holds. Writes to address 0 change nothing.
- R8: An event that arrives in the same cycle as a clear of its bit leaves that bit set.
- R9: When the unit is armed and any masked status bit is set, `irq_o` goes high for exactly one cycle, in the cycle after that condition is seen. The unit then disarms, and new events give no further pulse.
- R10: A write to the end-of-interrupt register (address 4) re-arms the unit. If any masked status bit is still pending, `irq_o` pulses in the second cycle after the write cycle. If none is pending, it stays low.
- R11: The end-of-interrupt register returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Event pulses, one bit per event source |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Each internal state shows up at the ports within a small, fixed number of cycles. A wrongly latched or wrongly cleared raw bit appears on the very next read of address 0 or 1. A bad mask update appears on the next read of address 2 or 3. A fault in the arm state can only be seen through `irq_o`. A missing pulse, an extra pulse or a stuck-high line shows up within two cycles of an event or of an end-of-interrupt write. For that reason the bench looks at `irq_o` in each of those cycles.

// File: rtl/dispc_irq_pkg.sv
package dispc_irq_pkg;
  localparam int EV_W   = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  // implemented event positions: 0,1,2,3,5,6,8,9
  localparam logic [EV_W-1:0] EV_PRESENT = 10'b11_0110_1111;

  typedef enum logic [ADDR_W-1:0] {
    A_RAW   = 3'd0,
    A_STAT  = 3'd1,
    A_ENSET = 3'd2,
    A_ENCLR = 3'd3,
    A_EOI   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/dispc_irq_latch.sv
module dispc_irq_latch #(
  parameter int EV_W = 10,
  parameter logic [EV_W-1:0] PRESENT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] evt,
  input  logic [EV_W-1:0] clr,
  output logic [EV_W-1:0] raw
);
  for (genvar i = 0; i < EV_W; i++) begin : g_bit
    if (PRESENT[i]) begin : g_flop
      logic bit_q;
      // a new event outranks a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= evt[i] | (bit_q & ~clr[i]);
      end
      assign raw[i] = bit_q;
    end else begin : g_tie
      assign raw[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dispc_irq_mask.sv
module dispc_irq_mask #(
  parameter int EV_W = 10,
  parameter logic [EV_W-1:0] PRESENT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_wr,
  input  logic            clr_wr,
  input  logic [EV_W-1:0] bits,
  output logic [EV_W-1:0] mask
);
  logic [EV_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_wr) mask_q <= mask_q | (bits & PRESENT);
    else if (clr_wr) mask_q <= mask_q & ~bits;
  end

  assign mask = mask_q;
endmodule

// File: rtl/dispc_irq_arm.sv
module dispc_irq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic rearm,
  output logic irq,
  output logic armed
);
  logic armed_q, irq_q, fire;

  assign fire = armed_q & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire;
      if (rearm)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  assign irq   = irq_q;
  assign armed = armed_q;
endmodule

// File: rtl/dispc_irq_ctrl.sv
module dispc_irq_ctrl #(
  parameter int EV_W   = dispc_irq_pkg::EV_W,
  parameter int DATA_W = dispc_irq_pkg::DATA_W,
  parameter int ADDR_W = dispc_irq_pkg::ADDR_W,
  parameter logic [EV_W-1:0] PRESENT = dispc_irq_pkg::EV_PRESENT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_W-1:0]   evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  import dispc_irq_pkg::*;

  logic [EV_W-1:0]   raw_q, mask_q, masked, clr_bits;
  logic [DATA_W-1:0] eoi_q;
  logic              wr_stat, wr_set, wr_clr, wr_eoi, armed_q;

  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign wr_set  = reg_wr && (reg_addr == ADDR_W'(A_ENSET));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(A_ENCLR));
  assign wr_eoi  = reg_wr && (reg_addr == ADDR_W'(A_EOI));

  assign clr_bits = wr_stat ? reg_wdata[EV_W-1:0] : '0;

  dispc_irq_latch #(.EV_W(EV_W), .PRESENT(PRESENT)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr_bits), .raw(raw_q)
  );

  dispc_irq_mask #(.EV_W(EV_W), .PRESENT(PRESENT)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_wr(wr_set), .clr_wr(wr_clr),
    .bits(reg_wdata[EV_W-1:0]), .mask(mask_q)
  );

  assign masked = raw_q & mask_q;

  dispc_irq_arm u_arm (
    .clk(clk), .rst_n(rst_n), .pend(|masked), .rearm(wr_eoi),
    .irq(irq_o), .armed(armed_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      eoi_q <= '0;
    else if (wr_eoi) eoi_q <= reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_RAW):   reg_rdata = DATA_W'(raw_q);
      ADDR_W'(A_STAT):  reg_rdata = DATA_W'(masked);
      ADDR_W'(A_ENSET),
      ADDR_W'(A_ENCLR): reg_rdata = DATA_W'(mask_q);
      ADDR_W'(A_EOI):   reg_rdata = eoi_q;
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dispc_irq_ctrl_chk.sv
module dispc_irq_ctrl_chk #(
  parameter int EV_W = 10,
  parameter int DATA_W = 16,
  parameter logic [EV_W-1:0] PRESENT = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EV_W-1:0]   evt_i,
  input logic [EV_W-1:0]   raw,
  input logic [EV_W-1:0]   mask,
  input logic              armed,
  input logic              eoi_wr,
  input logic              set_wr,
  input logic              clr_wr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_o
);
  // R2 / R8: a present event is latched at the next edge whatever else happens
  p_event_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_i & PRESENT) |=> ((raw & $past(evt_i & PRESENT)) == $past(evt_i & PRESENT)));

  // R4
  p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask & $past(wdata[EV_W-1:0] & PRESENT)) == $past(wdata[EV_W-1:0] & PRESENT)));

  // R5
  p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((mask & $past(wdata[EV_W-1:0])) == '0));

  // R9: a pulse needs armed and pending state one cycle earlier
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(armed) && $past(|(raw & mask))));

  // R9: single-cycle pulse unless a rearm came just before it
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (!irq_o || $past(eoi_wr, 2)));

  // R10
  p_eoi_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> armed);
endmodule

bind dispc_irq_ctrl dispc_irq_ctrl_chk #(.EV_W(EV_W), .DATA_W(DATA_W), .PRESENT(PRESENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .raw(raw_q), .mask(mask_q),
  .armed(armed_q), .eoi_wr(wr_eoi), .set_wr(wr_set), .clr_wr(wr_clr),
  .wdata(reg_wdata), .irq_o(irq_o)
);

// File: tb/dispc_irq_ctrl_test.sv
module dispc_irq_ctrl_test;
  localparam logic [9:0] IMPL = 10'b11_0110_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dispc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  // place the 8 bits of m on the implemented event positions
  function automatic logic [15:0] spread(input logic [7:0] m);
    logic [15:0] r = '0;
    int k = 0;
    for (int i = 0; i < 10; i++)
      if (IMPL[i]) begin
        r[i] = m[k];
        k++;
      end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] m16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk(d == 16'h0, "R1 reset read", d, 16'h0);
    end
    chk(irq_o == 1'b0, "R1 irq low", {15'b0, irq_o}, 16'h0);

    // R2/R3/R7: every event bit with mask off
    for (int b = 0; b < 10; b++) begin
      pulse(10'(1 << b));
      rd(3'd0, d);
      chk(d == (16'(1 << b) & 16'(IMPL)), "R2 raw latch", d, 16'(1 << b) & 16'(IMPL));
      rd(3'd1, d);
      chk(d == 16'h0, "R3 masked off", d, 16'h0);
      chk(irq_o == 1'b0, "R9 no irq when masked", {15'b0, irq_o}, 16'h0);
      wr(3'd1, 16'hFFFF);
      rd(3'd0, d);
      chk(d == 16'h0, "R7 clear all", d, 16'h0);
    end

    // R7: writes to raw address are ignored
    pulse(10'h3FF);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d);
    chk(d == 16'(IMPL), "R7 raw write ignored", d, 16'(IMPL));
    wr(3'd0, 16'h0000);
    rd(3'd0, d);
    chk(d == 16'(IMPL), "R7 raw write ignored", d, 16'(IMPL));

    // R4/R5/R6/R3 mask sweep
    for (int m = 0; m < 256; m++) begin
      m16 = spread(8'(m));
      wr(3'd3, 16'hFFFF);
      wr(3'd2, m16);
      wr(3'd2, 16'h0000);
      rd(3'd2, d);
      chk(d == m16, "R4 set mask", d, m16);
      rd(3'd3, d);
      chk(d == m16, "R6 mask on clr addr", d, m16);
      rd(3'd1, d);
      chk(d == m16, "R3 masked status", d, m16);
      wr(3'd2, 16'hFFFF);
      wr(3'd3, m16);
      wr(3'd3, 16'h0000);
      rd(3'd2, d);
      chk(d == (16'(IMPL) & ~m16), "R5 clear mask", d, 16'(IMPL) & ~m16);
    end

    // R7 partial write-one-to-clear sweep
    for (int m = 0; m < 256; m++) begin
      m16 = spread(8'(m));
      pulse(10'h3FF);
      wr(3'd1, m16);
      rd(3'd0, d);
      chk(d == (16'(IMPL) & ~m16), "R7 partial clear", d, 16'(IMPL) & ~m16);
    end

    // R8: event in the same cycle as its clear
    wr(3'd1, 16'hFFFF);
    pulse(10'h020);
    @(negedge clk);
    evt_i = 10'h020; reg_addr = 3'd1; reg_wdata = 16'h0320; reg_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0;
    rd(3'd0, d);
    chk(d == 16'h0020, "R8 event beats clear", d, 16'h0020);

    // R9/R10/R11 interrupt sequencing
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    wr(3'd4, 16'h0000);
    @(negedge clk);
    chk(irq_o == 1'b0, "R10 no pending no irq", {15'b0, irq_o}, 16'h0);
    pulse(10'h001);
    chk(irq_o == 1'b0, "R9 irq not yet", {15'b0, irq_o}, 16'h0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R9 irq pulse", {15'b0, irq_o}, 16'h1);
    @(negedge clk);
    chk(irq_o == 1'b0, "R9 one cycle", {15'b0, irq_o}, 16'h0);
    pulse(10'h200);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(irq_o == 1'b0, "R9 disarmed", {15'b0, irq_o}, 16'h0);
    end
    wr(3'd4, 16'h00A5);
    chk(irq_o == 1'b0, "R10 rearm delay", {15'b0, irq_o}, 16'h0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R10 rearm pulse", {15'b0, irq_o}, 16'h1);
    @(negedge clk);
    chk(irq_o == 1'b0, "R10 pulse ends", {15'b0, irq_o}, 16'h0);
    rd(3'd4, d);
    chk(d == 16'h00A5, "R11 eoi readback", d, 16'h00A5);
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'h1234);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(irq_o == 1'b0, "R10 rearm idle", {15'b0, irq_o}, 16'h0);
    end
    rd(3'd4, d);
    chk(d == 16'h1234, "R11 eoi readback", d, 16'h1234);
    pulse(10'h100);
    @(negedge clk);
    chk(irq_o == 1'b1, "R9 armed pulse", {15'b0, irq_o}, 16'h1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule